// File: doc/BRIEF.md
# Frequency-Hopping Slot Scheduler

This block produces the slot timing and the hop-channel sequence for the master side of a short-range, slotted time-division radio link. A free-running microsecond tick drives a slot timer. Each slot lasts `SLOT_US` ticks, 625 by default. At every slot boundary the block raises a one-cycle `slot_start` strobe. In the same cycle it presents the slot number, the transfer direction (master transmit or slave reply), the channel index for the slot and the slave being addressed.

A 16-bit maximal-length LFSR advances once per slot, and its state reduced modulo 79 gives the channel index. A frame is a master packet followed by a one-slot reply from the same slave. A master packet lasts 1, 3 or 5 slots, as set per slave through a small write-only register port. During a multi-slot packet the channel stays frozen. The LFSR keeps advancing underneath, so the reply lands on the hop belonging to its own slot number.

The master serves the slaves enabled in an activity mask in round-robin order. When the mask is empty it announces idle slots and sends nothing.

Top module: `fh_slot_sched`

## Requirements
- R1: `slot_start` is a one-cycle pulse. It rises in the cycle after the tick that completes each run of `SLOT_US` ticks. `slot_num` is 0 for the first slot after reset and rises by one at every pulse.
- R2: The channel of every slot that begins a packet, and of every idle slot, is S mod 79, which lies in 0..78. S is the LFSR state for that slot. The LFSR is reset to `LFSR_SEED` for slot 0 and steps once per slot by a left shift, with the new bit 0 equal to the XOR of bits 15, 13, 12 and 10.
- R3: Every master packet is followed by exactly one reply slot with `tx_dir`=0 and `idle_slot`=0, addressed to the same slave.
- R4: The 2-bit length code of a slave selects how many slots its packet lasts: 00 gives 1, 01 gives 3, 10 gives 5, and 11 gives 1. All slots of the packet have `tx_dir`=1.
- R5: Every continuation slot of a multi-slot packet carries the same channel as the first slot of that packet.
- R6: The reply slot after a packet of L slots that started at slot k uses the hop of slot k+L, not the hop of slot k+1.
- R7: `act_mask` bit i enables slave address i+1. A new frame goes to the lowest enabled address above the last served address, wrapping to the lowest enabled address. The last served address is 0 after reset.
- R8: If no slave is enabled when a frame would start, that slot has `idle_slot`=1, `tx_dir`=0 and `slave_id`=0. It still carries its hop channel, and the next slot tries again.
- R9: A length code written while a packet is in flight does not change that packet. It applies from the slave's next frame.
- R10: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle microsecond tick |
| act_mask | input | 7 | Slave enable, bit i for address i+1 |
| cfg_we | input | 1 | Length register write strobe |
| cfg_slave | input | 3 | Slave address written (1..7; 0 writes nothing) |
| cfg_code | input | 2 | Packet length code |
| slot_start | output | 1 | Slot boundary strobe |
| slot_num | output | SLOT_NUM_W | Slot number |
| tx_dir | output | 1 | 1 for master transmit, 0 for slave reply or idle |
| idle_slot | output | 1 | No packet in this slot |
| slave_id | output | 3 | Addressed slave |
| chan_idx | output | 7 | Channel index 0..78 |

## Verification
The assertions assume that `us_tick` never stays high on two cycles in a row. Under that assumption two slot boundaries can never fall on neighbouring cycles. The assertions also assume a slot period of at least two ticks. The stimulus raises the tick on every other cycle only. It changes `act_mask` and issues length writes only in cycles without a tick, so each boundary sees settled configuration. Random masks, including an empty one, are mixed with random length writes that often land in the middle of a packet. Directed phases exercise the empty mask, code 11 and a length change during a packet.

// File: rtl/fhs_pkg.sv
package fhs_pkg;
  localparam int SLV_MAX = 7;

  typedef enum logic [1:0] {PH_PICK, PH_MORE, PH_REPLY} phase_t;

  // number of slots a master packet lasts for a given length code
  function automatic logic [2:0] pkt_slots(input logic [1:0] code);
    case (code)
      2'b01:   return 3'd3;
      2'b10:   return 3'd5;
      default: return 3'd1;
    endcase
  endfunction

  // next enabled slave after 'last', wrapping; 0 when none is enabled
  function automatic logic [2:0] pick_next(input logic [SLV_MAX-1:0] mask,
                                           input logic [2:0] last);
    logic [2:0] r;
    int c;
    r = '0;
    for (int i = SLV_MAX; i >= 1; i--) begin
      c = ((int'(last) + i - 1) % SLV_MAX) + 1;
      if (mask[c-1]) r = 3'(c);
    end
    return r;
  endfunction

  // 16-bit maximal Fibonacci LFSR step, taps 16,14,13,11
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/fhs_slot_timer.sv
module fhs_slot_timer #(
  parameter int SLOT_US = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  output logic slot_edge
);
  localparam int CW = $clog2(SLOT_US);

  logic [CW-1:0] cnt_q;

  assign slot_edge = us_tick && (cnt_q == CW'(SLOT_US - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (us_tick) cnt_q <= slot_edge ? '0 : cnt_q + 1'b1;
  end

  // R1: tick counter never passes the slot length
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SLOT_US - 1));
  // R1: boundaries are isolated single-cycle events
  a_r1_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    slot_edge |=> !slot_edge);
endmodule

// File: rtl/fhs_hop_gen.sv
module fhs_hop_gen #(
  parameter int          NUM_CHAN = 79,
  parameter logic [15:0] SEED     = 16'hACE1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        advance,
  output logic [$clog2(NUM_CHAN)-1:0] chan
);
  import fhs_pkg::*;
  localparam int CH_W = $clog2(NUM_CHAN);

  logic [15:0] lfsr_q;

  assign chan = CH_W'(lfsr_q % 16'(NUM_CHAN));

  always_ff @(posedge clk) begin
    if (!rst_n)       lfsr_q <= SEED;
    else if (advance) lfsr_q <= lfsr_step(lfsr_q);
  end

  // R2: channel index stays within the channel set
  a_r2_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    chan < CH_W'(NUM_CHAN));
  // R2: the generator never locks up in the all-zero state
  a_r2_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0);
  // R2: hop state moves only on slot boundaries
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(lfsr_q));
endmodule

// File: rtl/fhs_len_regs.sv
module fhs_len_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [1:0] wr_code,
  input  logic [2:0] rd_addr,
  output logic [1:0] rd_code
);
  import fhs_pkg::*;

  logic [2*SLV_MAX-1:0] flat;

  for (genvar g = 1; g <= SLV_MAX; g++) begin : g_slv
    logic [1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               q <= 2'b00;
      else if (wr_en && wr_addr == 3'(g))       q <= wr_code;
    end
    assign flat[2*(g-1) +: 2] = q;
  end

  always_comb begin
    rd_code = 2'b00;
    for (int i = 1; i <= SLV_MAX; i++)
      if (rd_addr == 3'(i)) rd_code = flat[2*(i-1) +: 2];
  end
endmodule

// File: rtl/fhs_frame_seq.sv
module fhs_frame_seq #(
  parameter int SLOT_NUM_W = 16,
  parameter int CH_W       = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_edge,
  input  logic [6:0]            act_mask,
  input  logic [CH_W-1:0]       chan_now,
  output logic [2:0]            sel_addr,
  input  logic [1:0]            sel_code,
  output logic                  slot_start_o,
  output logic [SLOT_NUM_W-1:0] slot_num_o,
  output logic                  tx_o,
  output logic                  idle_o,
  output logic [2:0]            slave_o,
  output logic [CH_W-1:0]       chan_o
);
  import fhs_pkg::*;

  phase_t                phase_q;
  logic [2:0]            left_q;
  logic [2:0]            cur_q;
  logic [2:0]            last_q;
  logic [SLOT_NUM_W-1:0] num_q;
  logic [2:0]            sel_slots;

  assign sel_addr  = pick_next(act_mask, last_q);
  assign sel_slots = pkt_slots(sel_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= PH_PICK;
      left_q       <= '0;
      cur_q        <= '0;
      last_q       <= '0;
      num_q        <= '0;
      slot_start_o <= 1'b0;
      slot_num_o   <= '0;
      tx_o         <= 1'b0;
      idle_o       <= 1'b0;
      slave_o      <= '0;
      chan_o       <= '0;
    end else begin
      slot_start_o <= slot_edge;
      if (slot_edge) begin
        slot_num_o <= num_q;
        num_q      <= num_q + 1'b1;
        case (phase_q)
          PH_PICK: begin
            chan_o <= chan_now;
            if (sel_addr == 3'd0) begin
              idle_o  <= 1'b1;
              tx_o    <= 1'b0;
              slave_o <= '0;
            end else begin
              idle_o  <= 1'b0;
              tx_o    <= 1'b1;
              slave_o <= sel_addr;
              cur_q   <= sel_addr;
              last_q  <= sel_addr;
              left_q  <= sel_slots - 3'd1;
              phase_q <= (sel_slots == 3'd1) ? PH_REPLY : PH_MORE;
            end
          end
          PH_MORE: begin
            idle_o <= 1'b0;
            tx_o   <= 1'b1;
            left_q <= left_q - 3'd1;
            if (left_q == 3'd1) phase_q <= PH_REPLY;
          end
          default: begin
            idle_o  <= 1'b0;
            tx_o    <= 1'b0;
            slave_o <= cur_q;
            chan_o  <= chan_now;
            phase_q <= PH_PICK;
          end
        endcase
      end
    end
  end

  // R5: continuation slots keep the channel of the packet's first slot
  a_r5_hold_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && phase_q == PH_MORE) |=> $stable(chan_o));
  // R3: reply goes to the slave that was just served
  a_r3_reply_same: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && phase_q == PH_REPLY) |=> (!tx_o && !idle_o && slave_o == $past(slave_o)));
  // R8: idle slots address nobody and do not transmit
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start_o && idle_o) |-> (!tx_o && slave_o == 3'd0));
  // R7: a new frame only goes to an enabled slave
  a_r7_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && phase_q == PH_PICK && sel_addr != 3'd0) |-> act_mask[sel_addr - 3'd1]);
  // R4: remaining continuation count never exceeds a 5-slot packet
  a_r4_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= 3'd4);
endmodule

// File: rtl/fh_slot_sched.sv
module fh_slot_sched #(
  parameter int          SLOT_US    = 625,
  parameter int          SLOT_NUM_W = 16,
  parameter int          NUM_CHAN   = 79,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          us_tick,
  input  logic [6:0]                    act_mask,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_slave,
  input  logic [1:0]                    cfg_code,
  output logic                          slot_start,
  output logic [SLOT_NUM_W-1:0]         slot_num,
  output logic                          tx_dir,
  output logic                          idle_slot,
  output logic [2:0]                    slave_id,
  output logic [$clog2(NUM_CHAN)-1:0]   chan_idx
);
  localparam int CH_W = $clog2(NUM_CHAN);

  logic            slot_edge;
  logic [CH_W-1:0] chan_now;
  logic [2:0]      sel_addr;
  logic [1:0]      sel_code;

  fhs_slot_timer #(.SLOT_US(SLOT_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .slot_edge(slot_edge)
  );

  fhs_hop_gen #(.NUM_CHAN(NUM_CHAN), .SEED(LFSR_SEED)) u_hop (
    .clk(clk), .rst_n(rst_n), .advance(slot_edge), .chan(chan_now)
  );

  fhs_len_regs u_len (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_slave),
    .wr_code(cfg_code), .rd_addr(sel_addr), .rd_code(sel_code)
  );

  fhs_frame_seq #(.SLOT_NUM_W(SLOT_NUM_W), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_edge(slot_edge), .act_mask(act_mask),
    .chan_now(chan_now), .sel_addr(sel_addr), .sel_code(sel_code),
    .slot_start_o(slot_start), .slot_num_o(slot_num), .tx_o(tx_dir),
    .idle_o(idle_slot), .slave_o(slave_id), .chan_o(chan_idx)
  );
endmodule

// File: tb/sim_fh_slot_sched.sv
module sim_fh_slot_sched;
  localparam int          SLOT_US = 8;
  localparam logic [15:0] SEED    = 16'hACE1;
  localparam int          NSLOTS  = 1500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic [6:0] act_mask = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_slave = '0;
  logic [1:0] cfg_code = '0;
  logic        slot_start, tx_dir, idle_slot;
  logic [15:0] slot_num;
  logic [2:0]  slave_id;
  logic [6:0]  chan_idx;

  fh_slot_sched #(.SLOT_US(SLOT_US), .SLOT_NUM_W(16), .NUM_CHAN(79), .LFSR_SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .act_mask(act_mask),
    .cfg_we(cfg_we), .cfg_slave(cfg_slave), .cfg_code(cfg_code),
    .slot_start(slot_start), .slot_num(slot_num), .tx_dir(tx_dir),
    .idle_slot(idle_slot), .slave_id(slave_id), .chan_idx(chan_idx)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // bench-side restatements of the requirements
  function automatic logic [15:0] b_hop_next(input logic [15:0] s);
    return (s << 1) | 16'(^(s & 16'hB400));
  endfunction

  function automatic int b_len(input logic [1:0] code);
    if (code == 2'b01) return 3;
    if (code == 2'b10) return 5;
    return 1;
  endfunction

  function automatic int b_pick(input logic [6:0] m, input int last);
    int a;
    a = last;
    for (int n = 0; n < 7; n++) begin
      a = (a >= 7) ? 1 : a + 1;
      if (m[a-1]) return a;
    end
    return 0;
  endfunction

  // model state
  logic [15:0] m_lfsr = SEED;
  int m_num = 0, m_phase = 0, m_left = 0, m_cur = 0, m_last = 0, m_held = 0, m_len = 1;
  logic [1:0] m_tbl [1:7];

  task automatic model_slot();
    int hop, nxt;
    hop = int'(m_lfsr % 16'd79);
    chk("R1", "slot number", int'(slot_num), m_num & 16'hFFFF);
    case (m_phase)
      0: begin
        nxt = b_pick(act_mask, m_last);
        if (nxt == 0) begin
          chk("R8", "idle flag", int'(idle_slot), 1);
          chk("R8", "idle tx", int'(tx_dir), 0);
          chk("R8", "idle slave", int'(slave_id), 0);
          chk("R8", "idle chan", int'(chan_idx), hop);
        end else begin
          chk("R4", "first tx", int'(tx_dir), 1);
          chk("R8", "not idle", int'(idle_slot), 0);
          chk("R7", "rotation slave", int'(slave_id), nxt);
          chk("R2", "first chan", int'(chan_idx), hop);
          m_len = b_len(m_tbl[nxt]);
          m_left = m_len - 1;
          m_phase = (m_len == 1) ? 2 : 1;
          m_cur = nxt; m_last = nxt; m_held = hop;
        end
      end
      1: begin
        chk((b_len(m_tbl[m_cur]) != m_len) ? "R9" : "R4", "cont tx", int'(tx_dir), 1);
        chk("R4", "cont slave", int'(slave_id), m_cur);
        chk("R5", "cont chan held", int'(chan_idx), m_held);
        m_left--;
        if (m_left == 0) m_phase = 2;
      end
      default: begin
        chk("R3", "reply dir", int'(tx_dir), 0);
        chk("R3", "reply not idle", int'(idle_slot), 0);
        chk("R3", "reply slave", int'(slave_id), m_cur);
        chk((m_len > 1) ? "R6" : "R2", "reply chan", int'(chan_idx), hop);
        m_phase = 0;
      end
    endcase
    m_lfsr = b_hop_next(m_lfsr);
    m_num++;
  endtask

  task automatic do_write(input int a, input logic [1:0] c);
    cfg_we = 1'b1; cfg_slave = 3'(a); cfg_code = c;
    if (a >= 1 && a <= 7) m_tbl[a] = c;
  endtask

  initial begin : main
    int cyc, last_ss;
    bit tk;
    void'($urandom(32'd20240611));
    for (int i = 1; i <= 7; i++) m_tbl[i] = 2'b00;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset strobe", int'(slot_start), 0);
    chk("R10", "reset slot", int'(slot_num), 0);
    chk("R10", "reset tx", int'(tx_dir), 0);
    chk("R10", "reset idle", int'(idle_slot), 0);
    chk("R10", "reset slave", int'(slave_id), 0);
    chk("R10", "reset chan", int'(chan_idx), 0);
    rst_n = 1'b1;
    cyc = 0; last_ss = -1; tk = 0;
    while (m_num < NSLOTS) begin
      @(negedge clk);
      cyc++;
      if (slot_start) begin
        if (last_ss >= 0) chk("R1", "slot period", cyc - last_ss, 2 * SLOT_US);
        last_ss = cyc;
        model_slot();
      end
      cfg_we = 1'b0;
      tk = !tk;
      us_tick = tk;
      if (!tk) begin
        if (m_num < 6) act_mask = 7'b0;
        else if (m_num < 14) begin do_write(3, 2'b11); act_mask = 7'b0000100; end
        else if (m_num < 19) do_write(3, 2'b01);
        else if (m_num < 40) begin
          if (m_num == 19 || m_num == 27) do_write(3, 2'b10);
          else if (m_num == 22 || m_num == 33) do_write(5, 2'b01);
          act_mask = 7'b0010100;
        end else begin
          if ($urandom % 40 == 0) do_write(int'($urandom % 8), 2'($urandom));
          if ($urandom % 300 == 0) act_mask = 7'($urandom) & (($urandom % 5 == 0) ? 7'h00 : 7'h7F);
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule